// File: doc/BRIEF.md
# Interrupt request flag controller

This block holds the pending flags of ten interrupt sources in a small 8-bit controller: five timer overflows and five external request lines. Each source has a one-cycle set pulse and an enable bit. The block drives one request line per source to a priority encoder. The CPU sends an acknowledge with a source index when it enters a service routine. Software reads the flags and clears them through a single flag register.

The flags do not all clear the same way. The first `N_AUTO` timers and the first `N_AUTO` external lines clear themselves on acknowledge. The rest clear only through a software write. Each timer with a software-only clear also has a hidden pending flag, and that hidden flag drives its request. The hidden flag is wiped on the cycle in which its enable goes from 1 to 0. The visible bit of such a timer reads back as 0.

Each flag is held in a two-state machine (`FLG_IDLE`, `FLG_PEND`):
- The transition *raise* (IDLE→PEND) fires on a set pulse.
- The transition *drop* (PEND→IDLE) fires on a clear with no set pulse in the same cycle.
- The hidden flag uses the same two states. Its *drop* is caused by a software clear or by a falling edge of the enable.

Top module: `irq_flag_ctrl`

## Requirements
- R1: While reset is low, and on the first cycle after it, `rd_data` and `irq_req` are all 0. Reset clears every visible and hidden flag.
- R2: The source index layout is: timers at indices 0..4, external lines 0..4 at indices 5..9. A one-cycle pulse on `tmr_ovf[k]` sets flag k, and a pulse on `ext_req[k]` sets flag 5+k. The flag is visible from the next clock edge.
- R3: An acknowledge (`ack_vld`=1 with `ack_idx`=i) clears the flag of source i at the next edge when i is 0, 1, 5 or 6.
- R4: An acknowledge has no effect on the flags of sources 2, 3, 4, 7, 8 and 9.
- R5: A write with `wr_en`=1 clears every flag whose `wr_data` bit is 0. A bit written as 1 leaves its flag unchanged. For timers 2..4 the write also clears the hidden flag.
- R6: The `rd_data` bits 2, 3 and 4 (timers 2..4) always read 0. Every other bit shows its visible flag.
- R7: `irq_req[i]` is 1 exactly while source i is pending and `src_en[i]` is 1. For timers 2..4, "pending" means the hidden flag.
- R8: When `src_en` of timer 2, 3 or 4 falls from 1 to 0, its hidden flag clears at that edge. Re-enabling it then gives no request.
- R9: Dropping the enable of any other source does not clear its flag. The request comes back when the enable returns.
- R10: If a set pulse and a clear (acknowledge or write) hit the same flag in the same cycle, the flag is set.
- R11: An overflow of timer 2..4 while its enable is already 0 still sets the hidden flag. The request appears once the enable goes back to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tmr_ovf | input | N_TMR (5) | Timer overflow pulses |
| ext_req | input | N_EXT (5) | External request pulses |
| src_en | input | NSRC (10) | Per-source interrupt enable |
| ack_vld | input | 1 | CPU enters a service routine |
| ack_idx | input | IDXW (4) | Source index of the acknowledge |
| wr_en | input | 1 | Software write strobe for the flag register |
| wr_data | input | NSRC (10) | Write data; a 0 bit clears that flag |
| rd_data | output | NSRC (10) | Flag register read value |
| irq_req | output | NSRC (10) | Request vector to the priority encoder |

## Verification
The bench builds the block with the default values `N_TMR`=5, `N_EXT`=5 and `N_AUTO`=2. These values give every kind of cell:
- timers and external lines that clear on acknowledge,
- external lines that clear only in software,
- three hidden-flag timers.

With them the bench can cover acknowledge against each clear group, enable falling edges on hidden and non-hidden sources, and set/clear collisions through both clear paths.

// File: rtl/irq_flag_pkg.sv
package irq_flag_pkg;

    typedef enum logic {
        FLG_IDLE = 1'b0,
        FLG_PEND = 1'b1
    } flg_st_e;

    // Sources are laid out timers first, then external lines.
    function automatic bit src_is_timer(input int idx, input int n_tmr);
        return idx < n_tmr;
    endfunction

    // Position of a source inside its own group.
    function automatic int src_local(input int idx, input int n_tmr);
        return (idx < n_tmr) ? idx : idx - n_tmr;
    endfunction

    // The low group members clear themselves on acknowledge.
    function automatic bit src_auto(input int idx, input int n_tmr, input int n_auto);
        return src_local(idx, n_tmr) < n_auto;
    endfunction

    // Software-cleared timers carry a hidden pending flag.
    function automatic bit src_hidden(input int idx, input int n_tmr, input int n_auto);
        return src_is_timer(idx, n_tmr) && !src_auto(idx, n_tmr, n_auto);
    endfunction

endpackage

// File: rtl/irq_ack_dec.sv
module irq_ack_dec #(
    parameter int N_SRC = 10,
    parameter int IW    = 4
) (
    input  logic             vld_i,
    input  logic [IW-1:0]    idx_i,
    output logic [N_SRC-1:0] hit_o
);

    // One-hot decode of the acknowledged source; out-of-range index hits nothing.
    for (genvar i = 0; i < N_SRC; i++) begin : g_hit
        assign hit_o[i] = vld_i && (idx_i == IW'(i));
    end

endmodule

// File: rtl/irq_flag_cell.sv
module irq_flag_cell
    import irq_flag_pkg::*;
#(
    parameter bit AUTO_ACK = 1'b0,
    parameter bit HIDDEN   = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic ack_i,
    input  logic swclr_i,
    input  logic en_i,
    output logic rd_o,
    output logic req_o
);

    flg_st_e vis_q, vis_d;
    flg_st_e hid_q, hid_d;
    logic    en_q;
    logic    en_fall;
    logic    vis_clr;
    logic    hid_clr;

    assign en_fall = en_q && !en_i;
    assign vis_clr = swclr_i || (AUTO_ACK && ack_i);
    assign hid_clr = swclr_i || en_fall;

    // State registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vis_q <= FLG_IDLE;
            hid_q <= FLG_IDLE;
            en_q  <= 1'b0;
        end else begin
            vis_q <= vis_d;
            hid_q <= hid_d;
            en_q  <= en_i;
        end
    end

    // Visible flag: raise on set, drop on clear unless a set arrives too
    always_comb begin
        vis_d = vis_q;
        unique case (vis_q)
            FLG_IDLE: if (set_i) vis_d = FLG_PEND;
            FLG_PEND: if (!set_i && vis_clr) vis_d = FLG_IDLE;
            default:  vis_d = FLG_IDLE;
        endcase
    end

    // Hidden flag: only present on software-cleared timers
    always_comb begin
        hid_d = FLG_IDLE;
        if (HIDDEN) begin
            unique case (hid_q)
                FLG_IDLE: hid_d = set_i ? FLG_PEND : FLG_IDLE;
                FLG_PEND: hid_d = (!set_i && hid_clr) ? FLG_IDLE : FLG_PEND;
                default:  hid_d = FLG_IDLE;
            endcase
        end
    end

    // Outputs
    always_comb begin
        rd_o  = !HIDDEN && (vis_q == FLG_PEND);
        req_o = en_i && (HIDDEN ? (hid_q == FLG_PEND) : (vis_q == FLG_PEND));
    end

    // R10: a set pulse always leaves the flag pending
    a_r10_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> (vis_q == FLG_PEND));

    // R5: a software clear without a set empties the flag
    a_r5_sw_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (swclr_i && !set_i) |=> (vis_q == FLG_IDLE));

    if (AUTO_ACK) begin : g_auto_chk
        // R3: acknowledge clears auto-clear sources
        a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i && !set_i) |=> (vis_q == FLG_IDLE));
    end else begin : g_sw_chk
        // R4: acknowledge alone leaves software-cleared sources pending
        a_r4_ack_ignored: assert property (@(posedge clk) disable iff (!rst_n)
            (ack_i && !swclr_i && vis_q == FLG_PEND) |=> (vis_q == FLG_PEND));
    end

    if (HIDDEN) begin : g_hid_chk
        // R8: enable falling edge wipes the hidden flag
        a_r8_disable_wipes: assert property (@(posedge clk) disable iff (!rst_n)
            (en_q && !en_i && !set_i) |=> (hid_q == FLG_IDLE));
        // R5: hidden pending implies visible pending
        a_r5_hid_in_vis: assert property (@(posedge clk) disable iff (!rst_n)
            (hid_q == FLG_PEND) |-> (vis_q == FLG_PEND));
        // R6: hidden timers never show on the read port
        a_r6_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !rd_o);
    end

endmodule

// File: rtl/irq_flag_ctrl.sv
module irq_flag_ctrl
    import irq_flag_pkg::*;
#(
    parameter int N_TMR  = 5,
    parameter int N_EXT  = 5,
    parameter int N_AUTO = 2,
    localparam int NSRC  = N_TMR + N_EXT,
    localparam int IDXW  = $clog2(NSRC)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_TMR-1:0] tmr_ovf,
    input  logic [N_EXT-1:0] ext_req,
    input  logic [NSRC-1:0] src_en,
    input  logic            ack_vld,
    input  logic [IDXW-1:0] ack_idx,
    input  logic            wr_en,
    input  logic [NSRC-1:0] wr_data,
    output logic [NSRC-1:0] rd_data,
    output logic [NSRC-1:0] irq_req
);

    logic [NSRC-1:0] set_vec;
    logic [NSRC-1:0] ack_hit;
    logic [NSRC-1:0] sw_clr;

    assign set_vec = {ext_req, tmr_ovf};
    assign sw_clr  = {NSRC{wr_en}} & ~wr_data;

    irq_ack_dec #(
        .N_SRC (NSRC),
        .IW    (IDXW)
    ) u_ack (
        .vld_i (ack_vld),
        .idx_i (ack_idx),
        .hit_o (ack_hit)
    );

    for (genvar i = 0; i < NSRC; i++) begin : g_src
        irq_flag_cell #(
            .AUTO_ACK (src_auto(i, N_TMR, N_AUTO)),
            .HIDDEN   (src_hidden(i, N_TMR, N_AUTO))
        ) u_cell (
            .clk     (clk),
            .rst_n   (rst_n),
            .set_i   (set_vec[i]),
            .ack_i   (ack_hit[i]),
            .swclr_i (sw_clr[i]),
            .en_i    (src_en[i]),
            .rd_o    (rd_data[i]),
            .req_o   (irq_req[i])
        );
    end

    // R7: no request leaves for a disabled source
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_req & ~src_en) == '0);

    // R1: the cycle after reset starts with nothing pending
    a_r1_reset_empty: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0));

endmodule

// File: tb/sim_irq_flag_ctrl.sv
module sim_irq_flag_ctrl;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] tmr_ovf = '0;
    logic [4:0] ext_req = '0;
    logic [9:0] src_en = '0;
    logic       ack_vld = 1'b0;
    logic [3:0] ack_idx = '0;
    logic       wr_en = 1'b0;
    logic [9:0] wr_data = '0;
    logic [9:0] rd_data;
    logic [9:0] irq_req;

    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    irq_flag_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .tmr_ovf(tmr_ovf), .ext_req(ext_req),
        .src_en(src_en), .ack_vld(ack_vld), .ack_idx(ack_idx),
        .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .irq_req(irq_req)
    );

    typedef struct packed {
        logic [4:0] tmr;
        logic [4:0] ext;
        logic [9:0] en;
        logic       ack;
        logic [3:0] idx;
        logic       wr;
        logic [9:0] wd;
        logic [9:0] rd;
        logic [9:0] irq;
        logic [3:0] req;
    } vec_t;

    localparam int NV = 23;
    localparam vec_t TBL [NV] = '{
        '{5'h01, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h001, 10'h001, 4'd2},  // R2 T0 set
        '{5'h00, 5'h01, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h021, 10'h021, 4'd2},  // R2 X0 set
        '{5'h00, 5'h00, 10'h3FF, 1'b1, 4'd0, 1'b0, 10'h000, 10'h020, 10'h020, 4'd3},  // R3 ack T0
        '{5'h00, 5'h04, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h0A0, 10'h0A0, 4'd2},  // R2 X2 set
        '{5'h00, 5'h00, 10'h3FF, 1'b1, 4'd7, 1'b0, 10'h000, 10'h0A0, 10'h0A0, 4'd4},  // R4 ack X2 ignored
        '{5'h00, 5'h00, 10'h3FF, 1'b1, 4'd5, 1'b0, 10'h000, 10'h080, 10'h080, 4'd3},  // R3 ack X0
        '{5'h04, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h080, 10'h084, 4'd6},  // R6 T2 hidden read
        '{5'h00, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b1, 10'h37F, 10'h000, 10'h004, 4'd5},  // R5 clear X2
        '{5'h00, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b1, 10'h3FB, 10'h000, 10'h000, 4'd5},  // R5 clear T2
        '{5'h08, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h000, 10'h008, 4'd7},  // R7 T3 request
        '{5'h00, 5'h00, 10'h3F7, 1'b0, 4'd0, 1'b0, 10'h000, 10'h000, 10'h000, 4'd8},  // R8 disable T3
        '{5'h00, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h000, 10'h000, 4'd8},  // R8 re-enable, none
        '{5'h02, 5'h00, 10'h3FF, 1'b1, 4'd1, 1'b0, 10'h000, 10'h002, 10'h002, 4'd10}, // R10 set vs ack
        '{5'h00, 5'h00, 10'h3FD, 1'b0, 4'd0, 1'b0, 10'h000, 10'h002, 10'h000, 4'd9},  // R9 T1 disabled
        '{5'h00, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h002, 10'h002, 4'd9},  // R9 T1 back
        '{5'h00, 5'h00, 10'h3EF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h002, 10'h002, 4'd7},  // R7 T4 off
        '{5'h10, 5'h00, 10'h3EF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h002, 10'h002, 4'd11}, // R11 T4 set off
        '{5'h00, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h002, 10'h012, 4'd11}, // R11 T4 on
        '{5'h00, 5'h02, 10'h3FF, 1'b0, 4'd0, 1'b1, 10'h3ED, 10'h040, 10'h040, 4'd5},  // R5 clear T1,T4
        '{5'h00, 5'h02, 10'h3FF, 1'b0, 4'd0, 1'b1, 10'h3BF, 10'h040, 10'h040, 4'd10}, // R10 set vs write
        '{5'h00, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b1, 10'h000, 10'h000, 10'h000, 4'd5},  // R5 clear all
        '{5'h01, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b0, 10'h000, 10'h001, 10'h001, 4'd2},  // R2 T0 again
        '{5'h00, 5'h00, 10'h3FF, 1'b0, 4'd0, 1'b1, 10'h3FF, 10'h001, 10'h001, 4'd5}   // R5 write 1 keeps
    };

    task automatic check(input string what, input int rq, input logic [9:0] act, input logic [9:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL R%0d %s: actual=%h expected=%h", rq, what, act, exp);
        end
    endtask

    task automatic idle_inputs();
        tmr_ovf = '0; ext_req = '0; ack_vld = 1'b0; ack_idx = '0; wr_en = 1'b0; wr_data = '0;
    endtask

    initial begin
        #200000;
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1: reset state with all enables on
        src_en = 10'h3FF;
        tmr_ovf = 5'h1F;
        @(posedge clk); #1;
        check("rd in reset", 1, rd_data, 10'h000);
        check("irq in reset", 1, irq_req, 10'h000);
        @(negedge clk);
        idle_inputs();
        rst_n = 1'b1;
        @(posedge clk); #1;
        check("rd after reset", 1, rd_data, 10'h000);

        for (int k = 0; k < NV; k++) begin
            @(negedge clk);
            tmr_ovf = TBL[k].tmr; ext_req = TBL[k].ext; src_en = TBL[k].en;
            ack_vld = TBL[k].ack; ack_idx = TBL[k].idx;
            wr_en = TBL[k].wr; wr_data = TBL[k].wd;
            @(posedge clk); #1;
            check($sformatf("row %0d rd", k), int'(TBL[k].req), rd_data, TBL[k].rd);
            check($sformatf("row %0d irq", k), int'(TBL[k].req), irq_req, TBL[k].irq);
        end

        // R4: acknowledge of a hidden timer leaves its request up
        @(negedge clk); idle_inputs(); tmr_ovf = 5'h08;
        @(negedge clk); idle_inputs(); ack_vld = 1'b1; ack_idx = 4'd3;
        @(posedge clk); #1;
        check("ack T3 ignored", 4, irq_req, 10'h009);

        // R1: reset mid-run wipes visible and hidden flags
        @(negedge clk); idle_inputs(); rst_n = 1'b0;
        @(posedge clk); #1;
        check("mid reset irq", 1, irq_req, 10'h000);
        @(negedge clk); rst_n = 1'b1;
        @(posedge clk); #1;
        check("post reset rd", 1, rd_data, 10'h000);
        check("post reset irq", 1, irq_req, 10'h000);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule